// File: doc/BRIEF.md
# Memory Address Router with Folding and Movable Framebuffer

This block sits between a processor and its memory targets and decides, for every access, which of three targets it goes to: a small I/O region at the very top of the address space, a dual-port framebuffer RAM that is kept apart from main memory, or the cached main-memory path. It drives one select strobe for each target, along with an address already translated for that target.

The framebuffer window is not fixed. Software moves it by writing a base register in the I/O region, and the new base may lie anywhere in the address space, including above the 8 MB line. A second control bit turns folding on or off. With folding on, every main-memory address at or above 1 MB is folded onto the first megabyte by clearing address bit 20 and every bit above it. All outputs are combinational from the current address and the two control registers. Register writes take effect on the clock edge that ends the write cycle.

Top module: `addr_router`

## Requirements
- R1: After reset the framebuffer base is 0x0E7F00 and folding is on (the fold-enable bit reads as 1).
- R2: An address whose bits 23..8 are all ones is an I/O access. It raises ioSel, drives ioAddr with address bits 7..0, and takes priority over the framebuffer and main memory.
- R3: A non-I/O address with base ≤ addr < base + 0x18100 raises fbSel and drives fbAddr = addr − base (17 bits). The comparison uses the untranslated address, and the framebuffer takes priority over main memory.
- R4: Any other valid address raises memSel. memAddr equals addr with bits 23..20 cleared when folding is on, and equals addr unchanged when folding is off.
- R5: A write (cpuValid=1, cpuWe=1) to address 0xFFFFF0 loads cpuWData[23:0] into the framebuffer base. The new window is used from the next cycle on, and any 24-bit base is accepted.
- R6: A write to address 0xFFFFF4 loads cpuWData[0] into the fold-enable bit (1 = folding on). The new setting is used from the next cycle on.
- R7: When cpuValid=1, exactly one select is high. When cpuValid=0, no select is high. Any address output whose select is low is driven to zero.
- R8: A read of a control address, or a write to any other I/O offset, leaves both the framebuffer base and the fold-enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Access strobe from the processor |
| cpuWe | input | 1 | Write enable for the access |
| cpuAddr | input | 24 | Byte address of the access |
| cpuWData | input | 32 | Write data (used for control registers) |
| ioSel | output | 1 | I/O region select |
| ioAddr | output | 8 | Offset within the I/O region |
| fbSel | output | 1 | Framebuffer RAM select |
| fbAddr | output | 17 | Offset within the framebuffer window |
| memSel | output | 1 | Cached main-memory select |
| memAddr | output | 24 | Main-memory address after folding |

## Verification
The hardest cases come after the window has been moved. An address can then lie inside the new window but above 1 MB, so it would have folded into low memory if it had gone to main memory. The window can also be placed so that its top edge meets the I/O region. To reach these cases, the stimulus writes random bases, including bases above 8 MB and bases right below the I/O region, and then aims most addresses at the window edges (base−1, base, base+size−1, base+size). The fold-enable bit is toggled between these bursts.

// File: rtl/addr_router_pkg.sv
package addr_router_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int IO_W = 8;
  localparam int FOLD_BIT = 20;
  localparam logic [ADDR_W-1:0] FB_RESET_BASE = 24'h0E7F00;
  localparam int FB_SIZE = 'h18100;
  localparam int FB_OFF_W = $clog2(FB_SIZE);
  localparam logic [IO_W-1:0] REG_BASE_OFF = 8'hF0;
  localparam logic [IO_W-1:0] REG_FOLD_OFF = 8'hF4;

  typedef struct packed {
    logic isIo;
    logic loadBase;
    logic loadFold;
  } ctrlStrb_t;
endpackage

// File: rtl/addr_router_ctrl.sv
module addr_router_ctrl
  import addr_router_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  output ctrlStrb_t         strb
);
  localparam int HI_W = ADDR_W - IO_W;

  logic ioHit;
  logic ioWrite;

  assign ioHit   = cpuValid && (cpuAddr[ADDR_W-1:IO_W] == {HI_W{1'b1}});
  assign ioWrite = ioHit && cpuWe;

  always_comb begin
    strb = '0;
    strb.isIo     = ioHit;
    strb.loadBase = ioWrite && (cpuAddr[IO_W-1:0] == REG_BASE_OFF);
    strb.loadFold = ioWrite && (cpuAddr[IO_W-1:0] == REG_FOLD_OFF);
  end

  // R5/R6: a control write loads at most one register
  assert_single_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadBase, strb.loadFold}));
  // R8: loads only happen on writes
  assert_load_needs_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadBase || strb.loadFold) |-> (cpuWe && cpuValid));
endmodule

// File: rtl/addr_router_path.sv
module addr_router_path
  import addr_router_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic                cpuValid,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W-1:0]   cpuWData,
  output logic                ioSel,
  output logic [IO_W-1:0]     ioAddr,
  output logic                fbSel,
  output logic [FB_OFF_W-1:0] fbAddr,
  output logic                memSel,
  output logic [ADDR_W-1:0]   memAddr
);
  localparam int CMP_W = ADDR_W + 1;
  localparam logic [CMP_W-1:0] SIZE_EXT = CMP_W'(FB_SIZE);

  logic [ADDR_W-1:0] fbBase;
  logic              foldOn;
  logic [CMP_W-1:0]  addrExt;
  logic [CMP_W-1:0]  baseExt;
  logic [CMP_W-1:0]  limitExt;
  logic [ADDR_W-1:0] offFull;
  logic              inWindow;
  logic [ADDR_W-1:0] foldMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fbBase <= FB_RESET_BASE;
      foldOn <= 1'b1;
    end else begin
      if (strb.loadBase) fbBase <= cpuWData[ADDR_W-1:0];
      if (strb.loadFold) foldOn <= cpuWData[0];
    end
  end

  assign addrExt  = {1'b0, cpuAddr};
  assign baseExt  = {1'b0, fbBase};
  assign limitExt = baseExt + SIZE_EXT;
  assign inWindow = (addrExt >= baseExt) && (addrExt < limitExt);
  assign offFull  = cpuAddr - fbBase;

  generate
    for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
      if (b < FOLD_BIT) begin : g_keep
        assign foldMask[b] = 1'b1;
      end else begin : g_fold
        assign foldMask[b] = ~foldOn;
      end
    end
  endgenerate

  always_comb begin
    ioSel   = 1'b0;
    fbSel   = 1'b0;
    memSel  = 1'b0;
    ioAddr  = '0;
    fbAddr  = '0;
    memAddr = '0;
    if (cpuValid) begin
      if (strb.isIo) begin
        ioSel  = 1'b1;
        ioAddr = cpuAddr[IO_W-1:0];
      end else if (inWindow) begin
        fbSel  = 1'b1;
        fbAddr = offFull[FB_OFF_W-1:0];
      end else begin
        memSel  = 1'b1;
        memAddr = cpuAddr & foldMask;
      end
    end
  end

  // R7: exactly one target per valid access, none otherwise
  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> $countones({ioSel, fbSel, memSel}) == 1);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cpuValid |-> !(ioSel || fbSel || memSel));
  // R2: I/O wins over the other targets
  assert_io_priority_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.isIo |-> ioSel);
  // R3: framebuffer offset stays inside the window
  assert_fb_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    fbSel |-> (32'(fbAddr) < FB_SIZE));
  // R4: folded memory addresses stay below 1 MB
  assert_fold_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memSel && foldOn) |-> (memAddr[ADDR_W-1:FOLD_BIT] == '0));
  // R5/R8: base changes only through a load strobe, and takes the data
  assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadBase |=> $stable(fbBase));
  assert_base_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBase |=> fbBase == $past(cpuWData[ADDR_W-1:0]));
  // R6: fold bit changes only through its strobe
  assert_fold_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadFold |=> $stable(foldOn));
endmodule

// File: rtl/addr_router.sv
module addr_router
  import addr_router_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuValid,
  input  logic                cpuWe,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W-1:0]   cpuWData,
  output logic                ioSel,
  output logic [IO_W-1:0]     ioAddr,
  output logic                fbSel,
  output logic [FB_OFF_W-1:0] fbAddr,
  output logic                memSel,
  output logic [ADDR_W-1:0]   memAddr
);
  ctrlStrb_t strb;

  addr_router_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .strb(strb)
  );

  addr_router_path path_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuValid(cpuValid),
    .cpuAddr(cpuAddr), .cpuWData(cpuWData),
    .ioSel(ioSel), .ioAddr(ioAddr), .fbSel(fbSel), .fbAddr(fbAddr),
    .memSel(memSel), .memAddr(memAddr)
  );
endmodule

// File: tb/addr_router_tb_top.sv
`timescale 1ns/1ps
module addr_router_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0;
  logic        cpuWe = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic [31:0] cpuWData = '0;
  logic        ioSel, fbSel, memSel;
  logic [7:0]  ioAddr;
  logic [16:0] fbAddr;
  logic [23:0] memAddr;

  int errors = 0;
  int checks = 0;
  logic [23:0] mBase;
  logic        mFold;

  always #5 clk = ~clk;

  addr_router dut_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWData(cpuWData),
    .ioSel(ioSel), .ioAddr(ioAddr), .fbSel(fbSel), .fbAddr(fbAddr),
    .memSel(memSel), .memAddr(memAddr)
  );

  // expected outputs packed as {io,fb,mem,ioAddr,fbAddr,memAddr}
  function automatic logic [51:0] expect_out(logic v, logic [23:0] a,
                                              logic [23:0] base, logic fold);
    logic [24:0] lim;
    logic [23:0] off;
    lim = {1'b0, base} + 25'h18100;
    off = a - base;
    if (!v) return '0;
    if (a[23:8] == 16'hFFFF) return {3'b100, a[7:0], 17'd0, 24'd0};
    if ({1'b0, a} >= {1'b0, base} && {1'b0, a} < lim)
      return {3'b010, 8'd0, off[16:0], 24'd0};
    return {3'b001, 8'd0, 17'd0, fold ? {4'd0, a[19:0]} : a};
  endfunction

  task automatic check(string req);
    logic [51:0] exp, act;
    exp = expect_out(cpuValid, cpuAddr, mBase, mFold);
    act = {ioSel, fbSel, memSel, ioAddr, fbAddr, memAddr};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, cpuAddr, act, exp);
    end
  endtask

  task automatic access(logic v, logic we, logic [23:0] a, logic [31:0] d, string req);
    @(negedge clk);
    cpuValid = v; cpuWe = we; cpuAddr = a; cpuWData = d;
    #2 check(req);
    @(posedge clk);
    #1;
    if (v && we && a == 24'hFFFFF0) mBase = d[23:0];
    if (v && we && a == 24'hFFFFF4) mFold = d[0];
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] a;
    mBase = 24'h0E7F00;
    mFold = 1'b1;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset window base and folding on
    access(1, 0, 24'h0E7F00, 0, "R1");
    access(1, 0, 24'h0E7EFF, 0, "R1");
    access(1, 0, 24'h0FFFFF, 0, "R3");
    access(1, 0, 24'h100000, 0, "R4");
    access(1, 0, 24'h3E7F10, 0, "R4");
    access(0, 0, 24'h0E7F10, 0, "R7");
    // R2: I/O region priority and offset
    access(1, 0, 24'hFFFF00, 0, "R2");
    access(1, 0, 24'hFFFFFF, 0, "R2");
    access(1, 0, 24'hFFFEFF, 0, "R4");
    // R8: read of control regs, write to other io offset
    access(1, 0, 24'hFFFFF0, 32'h123456, "R8");
    access(1, 1, 24'hFFFFF8, 32'h0, "R8");
    access(1, 0, 24'h0E7F00, 0, "R8");
    access(1, 0, 24'h300000, 0, "R8");
    // R6: folding off
    access(1, 1, 24'hFFFFF4, 32'h0, "R6");
    access(1, 0, 24'h300000, 0, "R6");
    // R5: move window above 8 MB, next cycle in effect
    access(1, 1, 24'hFFFFF0, 32'h800000, "R5");
    access(1, 0, 24'h800000, 0, "R5");
    access(1, 0, 24'h0E7F00, 0, "R5");
    access(1, 0, 24'h8180FF, 0, "R3");
    access(1, 0, 24'h818100, 0, "R3");
    // window touching I/O region
    access(1, 1, 24'hFFFFF0, 32'hFF0000, "R5");
    access(1, 0, 24'hFFFEFF, 0, "R3");
    access(1, 0, 24'hFFFF00, 0, "R2");
    access(1, 1, 24'hFFFFF4, 32'h1, "R6");
    access(1, 0, 24'hF00000, 0, "R4");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 19);
      if (sel == 0) begin
        access(1, 1, 24'hFFFFF0, $urandom(), "R5");
      end else if (sel == 1) begin
        access(1, 1, 24'hFFFFF4, $urandom(), "R6");
      end else if (sel == 2) begin
        access(1, $urandom_range(0,1), {16'hFFFF, 8'($urandom())}, $urandom(), "R8");
      end else if (sel < 10) begin
        case ($urandom_range(0, 3))
          0: a = mBase - 24'd1;
          1: a = mBase;
          2: a = mBase + 24'h180FF;
          default: a = mBase + 24'h18100;
        endcase
        access(1, 0, a, 0, "R3");
      end else begin
        access($urandom_range(0, 7) != 0, 0, 24'($urandom()), 0, "R4");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule